// File: doc/BRIEF.md
# Card Host Status and Interrupt Register

This block holds the event status word and the interrupt enable word of a memory-card host controller. The protocol engine, the data buffers and the card-detect logic raise single-cycle event pulses. Each pulse sets a sticky flag that stays set until software clears it. Software clears a flag by writing a one to its bit position in the status word. Writing a zero to a bit leaves that bit as it is.

Some status bits are not stored. The buffer empty, full and ready bits and the card bus clock running bit show their live inputs directly. Stored error flags are ORed into one error summary output. A write-CRC event also loads a two-bit code that tells a missing CRC status token apart from a CRC mismatch.

A second word holds the interrupt enables. Each enable selects one status source. The selected sources are ORed and registered to drive a single active-high interrupt line. Both words sit on a one-bit address with a combinational read path.

Top module: `card_stat_irq`

## Requirements
- R1: After reset, every stored status bit, the two-bit write-CRC code, every enable bit and the irq output are 0.
- R2: An event pulse sets its status bit one clock later. The bit positions are: insert 31, remove 30, underrun 25, overflow 24, SDIO active 14, command response end 13, write done 12, read/transfer done 11, response CRC error 5, read CRC error 3, write CRC error 2, response timeout 1, read timeout 0.
- R3: A bus write with bus_addr=0 clears every stored status bit where bus_wdata holds a 1. Stored bits where bus_wdata holds a 0 keep their value.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is set afterwards.
- R5: Status bits 29 (Y empty), 28 (X empty), 27 (Y full), 26 (X full), 8 (bus clock running), 7 (buffer read ready) and 6 (buffer write ready) follow their inputs in the same cycle. Writes to these bits have no effect.
- R6: A write-CRC error event loads wr_crc_code into status bits [10:9]. The value 2 means the card sent no CRC status token; any other nonzero value means a CRC mismatch. Clearing bit 2 also clears bits [10:9] to 0.
- R7: err_any is high exactly when any of status bits 5, 3, 2, 1 or 0 is set.
- R8: A bus write with bus_addr=1 loads the enable word from bus_wdata masked with 0x0007F01F, and the write takes effect one clock later. Only bits 18..12 and 4..0 are writable; every other enable bit reads 0.
- R9: irq goes high one clock after any of these enable/status pairs is both set, and goes low one clock after none is: en0/st11, en1/st12, en2/st13, en3/st6, en4/st7, en13/st14, en14/st30, en15/st31.
- R10: Enable bits 18..16 (wake enables) and 12 (DAT0), and the error status bits, never raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 1 | Word select: 0 status, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word selected by bus_addr |
| ev_cmd_done | input | 1 | Command response end pulse |
| ev_rd_done | input | 1 | Read/transfer done pulse |
| ev_wr_done | input | 1 | Write operation done pulse |
| ev_resp_crc | input | 1 | Response CRC error pulse |
| ev_rd_crc | input | 1 | Read CRC error pulse |
| ev_wr_crc | input | 1 | Write CRC error pulse |
| wr_crc_code | input | 2 | Write-CRC status code, loaded when ev_wr_crc is high |
| ev_resp_to | input | 1 | Response timeout pulse |
| ev_rd_to | input | 1 | Read timeout pulse |
| ev_insert | input | 1 | Card insertion pulse |
| ev_remove | input | 1 | Card removal pulse |
| ev_sdio | input | 1 | SDIO interrupt pulse |
| ev_ovfl | input | 1 | Buffer overflow pulse |
| ev_unrun | input | 1 | Buffer underrun pulse |
| lv_yempty | input | 1 | Live Y buffer empty |
| lv_xempty | input | 1 | Live X buffer empty |
| lv_yfull | input | 1 | Live Y buffer full |
| lv_xfull | input | 1 | Live X buffer full |
| lv_clk_run | input | 1 | Live card bus clock running |
| lv_rd_rdy | input | 1 | Live buffer read ready |
| lv_wr_rdy | input | 1 | Live buffer write ready |
| irq | output | 1 | Registered interrupt, active high |
| err_any | output | 1 | Error summary |

## Verification
Stored status bits and enable bits change on the first rising edge after their pulse or write. The bench drives inputs at falling edges and samples at the next falling edge. irq passes through one more register, so every interrupt check looks at the falling edge after the status change and first confirms that irq is still low one cycle earlier. Live bits and err_any are combinational from inputs or state, so they are read one time unit after their inputs change, away from any edge.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int WORD_W = 32;
    localparam int CODE_W = 2;

    // stored status bit positions
    localparam int ST_INS   = 31;
    localparam int ST_REM   = 30;
    localparam int ST_UNR   = 25;
    localparam int ST_OVF   = 24;
    localparam int ST_SDIO  = 14;
    localparam int ST_CMD   = 13;
    localparam int ST_WRD   = 12;
    localparam int ST_RDD   = 11;
    localparam int ST_RCRC  = 5;
    localparam int ST_DCRC  = 3;
    localparam int ST_WCRC  = 2;
    localparam int ST_RTO   = 1;
    localparam int ST_DTO   = 0;
    // live bit positions
    localparam int LV_YEMP  = 29;
    localparam int LV_XEMP  = 28;
    localparam int LV_YFUL  = 27;
    localparam int LV_XFUL  = 26;
    localparam int LV_CLK   = 8;
    localparam int LV_RRDY  = 7;
    localparam int LV_WRDY  = 6;
    localparam int CODE_LO  = 9;

    localparam logic [WORD_W-1:0] STICKY_MASK = 32'hC300_782F;
    localparam logic [WORD_W-1:0] ERR_MASK    = 32'h0000_002F;
    localparam logic [WORD_W-1:0] EN_MASK     = 32'h0007_F01F;

    // interrupt sources: status position paired with enable position
    localparam int N_SRC = 8;
    localparam int SRC_ST [N_SRC] = '{ST_RDD, ST_WRD, ST_CMD, LV_WRDY, LV_RRDY, ST_SDIO, ST_REM, ST_INS};
    localparam int SRC_EN [N_SRC] = '{0, 1, 2, 3, 4, 13, 14, 15};

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [WORD_W-1:0] en;
        logic              irq;
    } ctl_t;
endpackage

// File: rtl/csi_sticky_bank.sv
module csi_sticky_bank #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] bits_o
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        for (int i = 0; i < W; i++) begin
            if (MASK[i]) begin
                // a set pulse overrides a clear in the same cycle
                bits_d[i] = set_i[i] | (bits_q[i] & ~clr_i[i]);
            end else begin
                bits_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/csi_irq_gate.sv
module csi_irq_gate
    import csi_pkg::*;
(
    input  logic [WORD_W-1:0] status_i,
    input  logic [WORD_W-1:0] en_i,
    output logic              hit_o
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = status_i[SRC_ST[g]] & en_i[SRC_EN[g]];
    end

    assign hit_o = |hit;
endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              ev_cmd_done,
    input  logic              ev_rd_done,
    input  logic              ev_wr_done,
    input  logic              ev_resp_crc,
    input  logic              ev_rd_crc,
    input  logic              ev_wr_crc,
    input  logic [1:0]        wr_crc_code,
    input  logic              ev_resp_to,
    input  logic              ev_rd_to,
    input  logic              ev_insert,
    input  logic              ev_remove,
    input  logic              ev_sdio,
    input  logic              ev_ovfl,
    input  logic              ev_unrun,
    input  logic              lv_yempty,
    input  logic              lv_xempty,
    input  logic              lv_yfull,
    input  logic              lv_xfull,
    input  logic              lv_clk_run,
    input  logic              lv_rd_rdy,
    input  logic              lv_wr_rdy,
    output logic              irq,
    output logic              err_any
);
    logic              wr_stat, wr_en;
    logic [WORD_W-1:0] set_v, clr_v, sticky_q, status_word, en_word;
    logic              irq_hit;
    ctl_t              ctl_d, ctl_q;

    assign wr_stat = bus_wr & ~bus_addr;
    assign wr_en   = bus_wr &  bus_addr;
    assign clr_v   = wr_stat ? bus_wdata : '0;

    always_comb begin
        set_v          = '0;
        set_v[ST_INS]  = ev_insert;
        set_v[ST_REM]  = ev_remove;
        set_v[ST_UNR]  = ev_unrun;
        set_v[ST_OVF]  = ev_ovfl;
        set_v[ST_SDIO] = ev_sdio;
        set_v[ST_CMD]  = ev_cmd_done;
        set_v[ST_WRD]  = ev_wr_done;
        set_v[ST_RDD]  = ev_rd_done;
        set_v[ST_RCRC] = ev_resp_crc;
        set_v[ST_DCRC] = ev_rd_crc;
        set_v[ST_WCRC] = ev_wr_crc;
        set_v[ST_RTO]  = ev_resp_to;
        set_v[ST_DTO]  = ev_rd_to;
    end

    csi_sticky_bank #(.W(WORD_W), .MASK(STICKY_MASK)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .bits_o (sticky_q)
    );

    always_comb begin
        status_word                         = sticky_q;
        status_word[LV_YEMP]                = lv_yempty;
        status_word[LV_XEMP]                = lv_xempty;
        status_word[LV_YFUL]                = lv_yfull;
        status_word[LV_XFUL]                = lv_xfull;
        status_word[LV_CLK]                 = lv_clk_run;
        status_word[LV_RRDY]                = lv_rd_rdy;
        status_word[LV_WRDY]                = lv_wr_rdy;
        status_word[CODE_LO+CODE_W-1:CODE_LO] = ctl_q.code;
    end

    assign en_word = ctl_q.en;

    csi_irq_gate u_gate (
        .status_i (status_word),
        .en_i     (en_word),
        .hit_o    (irq_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ev_wr_crc) begin
            ctl_d.code = wr_crc_code;
        end else if (wr_stat && bus_wdata[ST_WCRC]) begin
            ctl_d.code = '0;
        end
        if (wr_en) begin
            ctl_d.en = bus_wdata & EN_MASK;
        end
        ctl_d.irq = irq_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq       = ctl_q.irq;
    assign err_any   = |(sticky_q & ERR_MASK);
    assign bus_rdata = bus_addr ? en_word : status_word;
endmodule

// File: rtl/card_stat_irq_chk.sv
module card_stat_irq_chk
    import csi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              ev_cmd_done,
    input logic              lv_rd_rdy,
    input logic [WORD_W-1:0] status_word,
    input logic [WORD_W-1:0] en_word,
    input logic              irq
);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmd_done |=> status_word[ST_CMD]);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[ST_CMD] && !ev_cmd_done) |=> !status_word[ST_CMD]);

    // R5
    live_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[LV_RRDY] == lv_rd_rdy);

    // R8
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> (en_word == ($past(bus_wdata) & EN_MASK)));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_word[2] && status_word[ST_CMD]) |=> irq);
endmodule

bind card_stat_irq card_stat_irq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ev_cmd_done (ev_cmd_done),
    .lv_rd_rdy   (lv_rd_rdy),
    .status_word (status_word),
    .en_word     (en_word),
    .irq         (irq)
);

// File: tb/card_stat_irq_tb_top.sv
module card_stat_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [12:0] evs = '0;
    logic [1:0]  wr_crc_code = '0;
    logic [6:0]  lvs = '0;
    logic        irq, err_any;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    card_stat_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_cmd_done(evs[0]), .ev_rd_done(evs[1]), .ev_wr_done(evs[2]),
        .ev_resp_crc(evs[3]), .ev_rd_crc(evs[4]), .ev_wr_crc(evs[5]),
        .wr_crc_code(wr_crc_code), .ev_resp_to(evs[6]), .ev_rd_to(evs[7]),
        .ev_insert(evs[8]), .ev_remove(evs[9]), .ev_sdio(evs[10]),
        .ev_ovfl(evs[11]), .ev_unrun(evs[12]),
        .lv_yempty(lvs[0]), .lv_xempty(lvs[1]), .lv_yfull(lvs[2]), .lv_xfull(lvs[3]),
        .lv_clk_run(lvs[4]), .lv_rd_rdy(lvs[5]), .lv_wr_rdy(lvs[6]),
        .irq(irq), .err_any(err_any)
    );

    function automatic int ev_pos(input int i);
        case (i)
            0: return 13;  1: return 11;  2: return 12;  3: return 5;
            4: return 3;   5: return 2;   6: return 1;   7: return 0;
            8: return 31;  9: return 30;  10: return 14; 11: return 24;
            default: return 25;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic bwrite(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [12:0] m);
        @(negedge clk);
        evs = m;
        @(negedge clk);
        evs = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, v); chk("R1 status", v, 32'h0);
        rd(1'b1, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 err_any", {31'b0, err_any}, 32'h0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        for (int i = 0; i < 13; i++) begin
            pulse(13'(1) << i);
            rd(1'b0, v);
            chk($sformatf("R2 event %0d", i), v, 32'h1 << ev_pos(i));
            bwrite(1'b0, 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        pulse(13'h0007);                  // cmd, read done, write done
        bwrite(1'b0, 32'h0000_2000);
        rd(1'b0, v); chk("R3 partial clear", v, 32'h0000_1800);
        bwrite(1'b0, 32'h0000_1800);
        rd(1'b0, v); chk("R3 rest cleared", v, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        @(negedge clk);
        evs = 13'h0001; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h0000_2000;
        @(negedge clk);
        evs = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(1'b0, v); chk("R4 set beats clear", v, 32'h0000_2000);
        bwrite(1'b0, 32'h0000_2000);
    endtask

    task automatic t_live;
        logic [31:0] v;
        @(negedge clk);
        lvs = 7'h7F;
        rd(1'b0, v); chk("R5 live all high", v, 32'h3C00_01C0);
        bwrite(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R5 write ignored", v, 32'h3C00_01C0);
        lvs = 7'h05;                      // Y empty, Y full
        rd(1'b0, v); chk("R5 live mixed", v, 32'h2800_0000);
        lvs = '0;
    endtask

    task automatic t_code;
        logic [31:0] v;
        @(negedge clk);
        wr_crc_code = 2'd2; evs = 13'h0020;
        @(negedge clk);
        evs = '0; wr_crc_code = '0;
        rd(1'b0, v); chk("R6 no-token code", v, 32'h0000_0404);
        chk("R7 err_any on write crc", {31'b0, err_any}, 32'h1);
        bwrite(1'b0, 32'h0000_0004);
        rd(1'b0, v); chk("R6 code cleared with bit 2", v, 32'h0);
        chk("R7 err_any low", {31'b0, err_any}, 32'h0);
        pulse(13'h0040);                  // response timeout
        chk("R7 err_any on timeout", {31'b0, err_any}, 32'h1);
        bwrite(1'b0, 32'h0000_0002);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        bwrite(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); chk("R8 writable mask", v, 32'h0007_F01F);
        bwrite(1'b1, 32'h0000_0000);
        rd(1'b1, v); chk("R8 cleared", v, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        bwrite(1'b1, 32'h0000_0004);      // command end enable
        pulse(13'h0001);
        chk("R9 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq raised", {31'b0, irq}, 32'h1);
        bwrite(1'b0, 32'h0000_2000);
        chk("R9 irq still high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 irq dropped", {31'b0, irq}, 32'h0);
        bwrite(1'b1, 32'h0000_8000);      // insertion enable
        pulse(13'h0100);
        @(negedge clk);
        chk("R9 irq on insert", {31'b0, irq}, 32'h1);
        bwrite(1'b0, 32'h8000_0000);
        @(negedge clk);
        bwrite(1'b1, 32'h0000_0010);      // buffer read ready enable
        lvs = 7'h20;
        @(negedge clk);
        @(negedge clk);
        chk("R9 irq on live read ready", {31'b0, irq}, 32'h1);
        lvs = '0;
        bwrite(1'b1, 32'h0);
        @(negedge clk);
        rd(1'b1, v);
    endtask

    task automatic t_no_irq;
        logic [31:0] v;
        bwrite(1'b1, 32'h0007_1000);      // wake and DAT0 only
        pulse(13'h1FFF);
        @(negedge clk);
        @(negedge clk);
        chk("R10 wake enables silent", {31'b0, irq}, 32'h0);
        bwrite(1'b0, 32'hFFFF_FFFF);
        bwrite(1'b1, 32'h0000_F01F);      // every irq enable, errors only
        pulse(13'h00F8);
        @(negedge clk);
        @(negedge clk);
        chk("R10 errors silent", {31'b0, irq}, 32'h0);
        rd(1'b0, v);
        bwrite(1'b0, 32'hFFFF_FFFF);
        bwrite(1'b1, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_set_wins();
        t_live();
        t_code();
        t_enable();
        t_irq();
        t_no_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule